// File: doc/BRIEF.md
# Peripheral Security Access Gate

This block stands between one APB-style requester and a set of downstream peripheral ports. Each request carries a port index, a secure attribute and an unprivileged (user) attribute. Per-port configuration inputs say whether a port accepts only non-secure or only secure traffic, and whether unprivileged code may reach it. A constant parameter mask can exempt chosen ports from the security comparison. The privilege comparison still applies to those ports.

A permitted transfer is passed through to the selected port without change, and that port's response comes back to the requester. A refused transfer never reaches any port. The gate answers it itself in the access phase, with no wait states. It answers either with an error or silently: a read returns zero, a write is dropped, and the response is OK. Every refusal sets a sticky violation flag. The flag drives an interrupt, which is gated by an enable input. While the clear input is high, the flag is held at zero and new refusals are ignored.

Address decoding into port indices is done upstream. The configuration bits come from registers outside the block.

Top module: `periph_sec_gate`

## Requirements
- R1: A transfer to a port whose exemption bit is 0 is refused when its secure attribute equals that port's `cfg_nonsec` bit (secure=1 with cfg_nonsec=1, or secure=0 with cfg_nonsec=0).
- R2: A port whose bit in parameter `EXEMPT_MASK` is 1 skips the security comparison only. Such a port still accepts or refuses by the privilege rule.
- R3: A transfer with user=1 is refused when the port's `cfg_upriv_ok` bit is 0, whatever the exemption mask says.
- R4: A permitted transfer asserts `dn_psel` only for the indexed port. It forwards penable, pwrite, paddr, pwdata, pstrb, secure and user unchanged. It returns that port's prdata, pready and pslverr.
- R5: A refused transfer asserts no bit of `dn_psel` and does not assert `dn_penable`. It completes with `up_pready`=1 in the access phase, whatever the downstream ready signals are.
- R6: A refused transfer returns `up_pslverr` equal to `cfg_err_resp`. When `cfg_err_resp` is 0, a refused read also returns `up_prdata`=0.
- R7: A refused access phase sets the sticky violation flag at that clock edge. A refused access phase has no effect on the flag while `irq_clr` is 1. A permitted transfer, including one with a downstream error, does not set the flag.
- R8: `irq` is the flag ANDed with `irq_en`. It follows a change of `irq_en` within the same cycle.
- R9: A cycle with `irq_clr`=1 leaves the flag at 0 after the next clock edge.
- R10: While reset is asserted, and right after it, the flag is 0, so `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nonsec | input | NPORT | Per-port: 1 = non-secure only, 0 = secure only |
| cfg_upriv_ok | input | NPORT | Per-port: 1 = unprivileged access allowed |
| cfg_err_resp | input | 1 | 1 = refused transfers get an error response |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the violation flag and suppresses new settings |
| irq | output | 1 | Violation interrupt |
| up_psel | input | 1 | Requester select |
| up_penable | input | 1 | Requester access phase |
| up_pwrite | input | 1 | Requester write |
| up_port | input | $clog2(NPORT) | Target port index |
| up_paddr | input | ADDR_W | Requester address |
| up_pwdata | input | DATA_W | Requester write data |
| up_pstrb | input | DATA_W/8 | Byte strobes (little-endian lanes) |
| up_secure | input | 1 | 1 = secure transfer |
| up_user | input | 1 | 1 = unprivileged transfer |
| up_prdata | output | DATA_W | Read data to requester |
| up_pready | output | 1 | Ready to requester |
| up_pslverr | output | 1 | Error to requester |
| dn_psel | output | NPORT | Per-port select |
| dn_penable | output | 1 | Downstream access phase |
| dn_pwrite | output | 1 | Downstream write |
| dn_paddr | output | ADDR_W | Downstream address |
| dn_pwdata | output | DATA_W | Downstream write data |
| dn_pstrb | output | DATA_W/8 | Downstream strobes |
| dn_secure | output | 1 | Forwarded secure attribute |
| dn_user | output | 1 | Forwarded unprivileged attribute |
| dn_prdata | input | NPORT*DATA_W | Read data, port k at bits k*DATA_W upward |
| dn_pready | input | NPORT | Per-port ready |
| dn_pslverr | input | NPORT | Per-port error |

## Verification
On every cycle, the assertions check the following port-level rules:
- At most one port is selected at a time.
- An access phase with no port selected completes locally, with the response R6 prescribes.
- The interrupt never rises without its enable.
- The flag stays set until cleared, and a clear always takes effect.

Which attribute combinations are refused can only be shown by the bench scenarios. So can the following:
- a refusal while clear is held leaves no trace;
- a downstream error does not count as a violation;
- fields are forwarded unchanged.

The bench walks all 32 combinations of secure, user, non-secure bit, permit bit and exemption against its own reference.

// File: rtl/psg_pkg.sv
package psg_pkg;
  typedef struct packed {
    logic sec_fail;
    logic priv_fail;
  } psg_verdict_t;
endpackage

// File: rtl/psg_rst_sync.sv
module psg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/psg_rule_check.sv
module psg_rule_check #(
  parameter int          NPORT       = 16,
  parameter logic [NPORT-1:0] EXEMPT_MASK = '0
) (
  input  logic [$clog2(NPORT)-1:0] port_idx,
  input  logic                     req_secure,
  input  logic                     req_user,
  input  logic [NPORT-1:0]         cfg_nonsec,
  input  logic [NPORT-1:0]         cfg_upriv_ok,
  output psg_pkg::psg_verdict_t    verdict
);
  logic [NPORT-1:0] sec_fail_vec;
  logic [NPORT-1:0] priv_fail_vec;

  for (genvar k = 0; k < NPORT; k++) begin : g_port
    if (EXEMPT_MASK[k]) begin : g_exempt
      assign sec_fail_vec[k] = 1'b0;
    end else begin : g_checked
      assign sec_fail_vec[k] = (req_secure == cfg_nonsec[k]);
    end
    assign priv_fail_vec[k] = req_user & ~cfg_upriv_ok[k];
  end

  always_comb begin
    if (32'(port_idx) < NPORT) begin
      verdict.sec_fail  = sec_fail_vec[port_idx];
      verdict.priv_fail = priv_fail_vec[port_idx];
    end else begin
      verdict.sec_fail  = 1'b1;
      verdict.priv_fail = 1'b0;
    end
  end
endmodule

// File: rtl/psg_route.sv
module psg_route #(
  parameter int NPORT  = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                     blocked,
  input  logic                     cfg_err_resp,
  input  logic                     up_psel,
  input  logic                     up_penable,
  input  logic                     up_pwrite,
  input  logic [$clog2(NPORT)-1:0] up_port,
  input  logic [ADDR_W-1:0]        up_paddr,
  input  logic [DATA_W-1:0]        up_pwdata,
  input  logic [DATA_W/8-1:0]      up_pstrb,
  input  logic                     up_secure,
  input  logic                     up_user,
  output logic [DATA_W-1:0]        up_prdata,
  output logic                     up_pready,
  output logic                     up_pslverr,
  output logic [NPORT-1:0]         dn_psel,
  output logic                     dn_penable,
  output logic                     dn_pwrite,
  output logic [ADDR_W-1:0]        dn_paddr,
  output logic [DATA_W-1:0]        dn_pwdata,
  output logic [DATA_W/8-1:0]      dn_pstrb,
  output logic                     dn_secure,
  output logic                     dn_user,
  input  logic [NPORT*DATA_W-1:0]  dn_prdata,
  input  logic [NPORT-1:0]         dn_pready,
  input  logic [NPORT-1:0]         dn_pslverr
);
  logic pass;
  assign pass = up_psel & ~blocked;

  for (genvar k = 0; k < NPORT; k++) begin : g_sel
    assign dn_psel[k] = pass & (32'(up_port) == k);
  end

  assign dn_penable = pass & up_penable;
  assign dn_pwrite  = up_pwrite;
  assign dn_paddr   = up_paddr;
  assign dn_pwdata  = up_pwdata;
  assign dn_pstrb   = up_pstrb;
  assign dn_secure  = up_secure;
  assign dn_user    = up_user;

  always_comb begin
    up_prdata  = '0;
    up_pready  = 1'b0;
    up_pslverr = 1'b0;
    if (blocked) begin
      up_pready  = 1'b1;
      up_pslverr = cfg_err_resp;
    end else if (32'(up_port) < NPORT) begin
      up_prdata  = dn_prdata[up_port*DATA_W +: DATA_W];
      up_pready  = dn_pready[up_port];
      up_pslverr = dn_pslverr[up_port];
    end
  end
endmodule

// File: rtl/psg_violation.sv
module psg_violation (
  input  logic clk,
  input  logic rst_n,
  input  logic viol_evt,
  input  logic irq_clr,
  input  logic irq_en,
  output logic irq
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = irq_clr | viol_evt;
    flag_d  = irq_clr ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq = flag_q & irq_en;
endmodule

// File: rtl/periph_sec_gate.sv
module periph_sec_gate #(
  parameter int               NPORT       = 16,
  parameter int               ADDR_W      = 12,
  parameter int               DATA_W      = 32,
  parameter logic [NPORT-1:0] EXEMPT_MASK = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPORT-1:0]         cfg_nonsec,
  input  logic [NPORT-1:0]         cfg_upriv_ok,
  input  logic                     cfg_err_resp,
  input  logic                     irq_en,
  input  logic                     irq_clr,
  output logic                     irq,
  input  logic                     up_psel,
  input  logic                     up_penable,
  input  logic                     up_pwrite,
  input  logic [$clog2(NPORT)-1:0] up_port,
  input  logic [ADDR_W-1:0]        up_paddr,
  input  logic [DATA_W-1:0]        up_pwdata,
  input  logic [DATA_W/8-1:0]      up_pstrb,
  input  logic                     up_secure,
  input  logic                     up_user,
  output logic [DATA_W-1:0]        up_prdata,
  output logic                     up_pready,
  output logic                     up_pslverr,
  output logic [NPORT-1:0]         dn_psel,
  output logic                     dn_penable,
  output logic                     dn_pwrite,
  output logic [ADDR_W-1:0]        dn_paddr,
  output logic [DATA_W-1:0]        dn_pwdata,
  output logic [DATA_W/8-1:0]      dn_pstrb,
  output logic                     dn_secure,
  output logic                     dn_user,
  input  logic [NPORT*DATA_W-1:0]  dn_prdata,
  input  logic [NPORT-1:0]         dn_pready,
  input  logic [NPORT-1:0]         dn_pslverr
);
  psg_pkg::psg_verdict_t verdict;
  logic blocked, viol_evt, rst_n_sync;

  psg_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync));

  psg_rule_check #(.NPORT(NPORT), .EXEMPT_MASK(EXEMPT_MASK)) u_rule (
    .port_idx(up_port), .req_secure(up_secure), .req_user(up_user),
    .cfg_nonsec(cfg_nonsec), .cfg_upriv_ok(cfg_upriv_ok), .verdict(verdict)
  );

  assign blocked  = verdict.sec_fail | verdict.priv_fail;
  assign viol_evt = up_psel & up_penable & blocked;

  psg_route #(.NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .blocked(blocked), .cfg_err_resp(cfg_err_resp),
    .up_psel(up_psel), .up_penable(up_penable), .up_pwrite(up_pwrite),
    .up_port(up_port), .up_paddr(up_paddr), .up_pwdata(up_pwdata),
    .up_pstrb(up_pstrb), .up_secure(up_secure), .up_user(up_user),
    .up_prdata(up_prdata), .up_pready(up_pready), .up_pslverr(up_pslverr),
    .dn_psel(dn_psel), .dn_penable(dn_penable), .dn_pwrite(dn_pwrite),
    .dn_paddr(dn_paddr), .dn_pwdata(dn_pwdata), .dn_pstrb(dn_pstrb),
    .dn_secure(dn_secure), .dn_user(dn_user), .dn_prdata(dn_prdata),
    .dn_pready(dn_pready), .dn_pslverr(dn_pslverr)
  );

  psg_violation u_viol (
    .clk(clk), .rst_n(rst_n_sync), .viol_evt(viol_evt),
    .irq_clr(irq_clr), .irq_en(irq_en), .irq(irq)
  );
endmodule

// File: rtl/periph_sec_gate_chk.sv
module periph_sec_gate_chk #(
  parameter int NPORT  = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_err_resp,
  input logic              irq_en,
  input logic              irq_clr,
  input logic              irq,
  input logic              up_psel,
  input logic              up_penable,
  input logic [DATA_W-1:0] up_prdata,
  input logic              up_pready,
  input logic              up_pslverr,
  input logic [NPORT-1:0]  dn_psel,
  input logic              dn_penable
);
  a_r4_single_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dn_psel));

  a_r5_local_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (up_psel && up_penable && dn_psel == '0) |-> (up_pready && !dn_penable));

  a_r6_error_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (up_psel && up_penable && dn_psel == '0) |-> (up_pslverr == cfg_err_resp));

  a_r6_silent_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (up_psel && up_penable && dn_psel == '0 && !cfg_err_resp) |-> (up_prdata == '0));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> (irq || !irq_en));

  a_r8_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r10_reset_quiet: assert (!irq);
    end
  end
endmodule

bind periph_sec_gate periph_sec_gate_chk #(.NPORT(NPORT), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_err_resp(cfg_err_resp), .irq_en(irq_en),
  .irq_clr(irq_clr), .irq(irq), .up_psel(up_psel), .up_penable(up_penable),
  .up_prdata(up_prdata), .up_pready(up_pready), .up_pslverr(up_pslverr),
  .dn_psel(dn_psel), .dn_penable(dn_penable)
);

// File: tb/periph_sec_gate_tb_top.sv
module periph_sec_gate_tb_top;
  localparam int NPORT = 16, ADDR_W = 12, DATA_W = 32, PW = $clog2(NPORT);
  localparam logic [NPORT-1:0] EXEMPT = 16'h0020;

  // entry = {secure, user, nonsec, permit, exempt_port, expect_refused}
  localparam logic [5:0] VEC [32] = '{
    6'b000001, 6'b000010, 6'b000101, 6'b000110, 6'b001000, 6'b001010, 6'b001100, 6'b001110,
    6'b010001, 6'b010011, 6'b010101, 6'b010110, 6'b011001, 6'b011011, 6'b011100, 6'b011110,
    6'b100000, 6'b100010, 6'b100100, 6'b100110, 6'b101001, 6'b101010, 6'b101101, 6'b101110,
    6'b110001, 6'b110011, 6'b110100, 6'b110110, 6'b111001, 6'b111011, 6'b111101, 6'b111110};

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic [NPORT-1:0] cfg_nonsec = '0, cfg_upriv_ok = '0;
  logic cfg_err_resp = 0, irq_en = 0, irq_clr = 0, irq;
  logic up_psel = 0, up_penable = 0, up_pwrite = 0, up_secure = 0, up_user = 0;
  logic [PW-1:0] up_port = '0;
  logic [ADDR_W-1:0] up_paddr = '0;
  logic [DATA_W-1:0] up_pwdata = '0, up_prdata;
  logic [DATA_W/8-1:0] up_pstrb = '0, dn_pstrb;
  logic up_pready, up_pslverr;
  logic [NPORT-1:0] dn_psel, dn_pready = '1, dn_pslverr = '0;
  logic dn_penable, dn_pwrite, dn_secure, dn_user;
  logic [ADDR_W-1:0] dn_paddr;
  logic [DATA_W-1:0] dn_pwdata;
  logic [NPORT*DATA_W-1:0] dn_prdata;

  always_comb
    for (int k = 0; k < NPORT; k++) dn_prdata[k*DATA_W +: DATA_W] = 32'hC0DE0000 + k;

  periph_sec_gate #(.NPORT(NPORT), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXEMPT_MASK(EXEMPT)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_nonsec(cfg_nonsec), .cfg_upriv_ok(cfg_upriv_ok),
    .cfg_err_resp(cfg_err_resp), .irq_en(irq_en), .irq_clr(irq_clr), .irq(irq),
    .up_psel(up_psel), .up_penable(up_penable), .up_pwrite(up_pwrite), .up_port(up_port),
    .up_paddr(up_paddr), .up_pwdata(up_pwdata), .up_pstrb(up_pstrb), .up_secure(up_secure),
    .up_user(up_user), .up_prdata(up_prdata), .up_pready(up_pready), .up_pslverr(up_pslverr),
    .dn_psel(dn_psel), .dn_penable(dn_penable), .dn_pwrite(dn_pwrite), .dn_paddr(dn_paddr),
    .dn_pwdata(dn_pwdata), .dn_pstrb(dn_pstrb), .dn_secure(dn_secure), .dn_user(dn_user),
    .dn_prdata(dn_prdata), .dn_pready(dn_pready), .dn_pslverr(dn_pslverr));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // sampled in the access phase
  logic [NPORT-1:0] s_sel;
  logic s_en, s_rdy, s_err;
  logic [DATA_W-1:0] s_rd;

  task automatic xfer(bit wr, int port, bit sec, bit usr);
    @(negedge clk);
    up_psel = 1; up_penable = 0; up_pwrite = wr; up_port = PW'(port);
    up_secure = sec; up_user = usr; up_paddr = 12'h5A4; up_pwdata = 32'h1234ABCD; up_pstrb = 4'b0011;
    @(negedge clk);
    up_penable = 1;
    #1;
    s_sel = dn_psel; s_en = dn_penable; s_rdy = up_pready; s_err = up_pslverr; s_rd = up_prdata;
    @(negedge clk);
    up_psel = 0; up_penable = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    chk("R10 irq in reset", irq, 0);
    irq_en = 1;
    #1 chk("R10 irq in reset with enable", irq, 0);
    chk("R10 no select in reset", dn_psel, 0);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R10 irq after reset", irq, 0);

    // table of all attribute combinations (R1 R2 R3 R5 R6 R7)
    for (int i = 0; i < 32; i++) begin
      logic [5:0] v;
      int port;
      string tag;
      v = VEC[i];
      port = v[1] ? 5 : 2;
      tag = v[1] ? "R2" : (v[4] ? "R3" : "R1");
      @(negedge clk);
      irq_clr = 1;
      cfg_nonsec = '0; cfg_upriv_ok = '0;
      cfg_nonsec[port] = v[3]; cfg_upriv_ok[port] = v[2];
      cfg_err_resp = i[1];
      @(negedge clk) irq_clr = 0;
      xfer(i[0], port, v[5], v[4]);
      chk($sformatf("%s sel vec%0d", tag, i), s_sel, v[0] ? 0 : (1 << port));
      chk($sformatf("R5 ready vec%0d", i), s_rdy, 1);
      if (v[0]) begin
        chk($sformatf("R6 err vec%0d", i), s_err, i[1]);
        if (!i[0] && !i[1]) chk($sformatf("R6 zero read vec%0d", i), s_rd, 0);
      end else if (!i[0]) begin
        chk($sformatf("R4 read data vec%0d", i), s_rd, 32'hC0DE0000 + port);
      end
      chk($sformatf("R7 flag vec%0d", i), irq, v[0]);
    end

    // R4: forwarding, downstream wait and downstream error
    @(negedge clk) irq_clr = 1;
    cfg_nonsec = '0; cfg_nonsec[7] = 1; cfg_upriv_ok = '0; cfg_err_resp = 0;
    @(negedge clk) irq_clr = 0;
    dn_pready[7] = 0; dn_pslverr[7] = 1;
    @(negedge clk);
    up_psel = 1; up_pwrite = 1; up_port = 7; up_secure = 0; up_user = 0;
    up_paddr = 12'h3C8; up_pwdata = 32'hFEED0042; up_pstrb = 4'b1001;
    @(negedge clk) up_penable = 1;
    #1;
    chk("R4 sel", dn_psel, 16'h0080);
    chk("R4 penable", dn_penable, 1);
    chk("R4 fields", {dn_pwrite, dn_secure, dn_user, dn_paddr, dn_pstrb, dn_pwdata},
        {1'b1, 1'b0, 1'b0, 12'h3C8, 4'b1001, 32'hFEED0042});
    chk("R4 wait state", up_pready, 0);
    chk("R4 slave error", up_pslverr, 1);
    @(negedge clk) dn_pready[7] = 1;
    #1 chk("R4 ready", up_pready, 1);
    @(negedge clk) up_psel = 0; up_penable = 0;
    dn_pslverr[7] = 0;
    chk("R7 no flag on permitted error", irq, 0);

    // R5: refused access completes while downstream stalls
    dn_pready = '0; cfg_err_resp = 1;
    xfer(0, 7, 1, 0);
    chk("R5 ready despite stall", s_rdy, 1);
    chk("R5 no penable", s_en, 0);
    chk("R6 error resp", s_err, 1);
    dn_pready = '1;
    chk("R7 flag set", irq, 1);

    // R9: clear
    @(negedge clk) irq_clr = 1;
    @(negedge clk);
    chk("R9 cleared", irq, 0);

    // R7: clear held suppresses
    xfer(1, 7, 1, 0);
    @(negedge clk) irq_clr = 0;
    @(negedge clk);
    chk("R7 suppressed while clear held", irq, 0);

    // R8: enable gating follows same cycle
    irq_en = 0;
    xfer(0, 7, 1, 1);
    chk("R8 gated off", irq, 0);
    irq_en = 1;
    #1 chk("R8 enable follows", irq, 1);
    irq_en = 0;
    #1 chk("R8 disable follows", irq, 0);
    irq_en = 1;
    #1 chk("R7 flag kept while disabled", irq, 1);

    finish_run();
  end
endmodule